// File: doc/BRIEF.md
# Serial Register Write Loader

This block receives configuration values that arrive one bit at a time, one bit per processor write cycle. Each write carries a data byte; only its top bit and its bottom bit matter. A write with the top bit clear feeds the bottom bit into an internal shift register, least significant bit first. The fifth such write supplies the last bit, and the complete 5-bit value is committed to one of four holding registers. A two-bit register select that comes with that fifth write picks the target. The shift register then empties by itself, ready for the next value.

A write with the top bit set abandons any partial value. It also forces two mode bits of the control register to ones and raises a one-cycle pulse. The block also filters the write strobe. A write that lands in the cycle right after another write cycle is discarded completely, so a read-modify-write instruction that writes twice in a row acts only on its first write. The four registers drive the address translation logic nearby, which is not part of this block.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset the shift register is empty, `ctrl_q` is 5'b01100, `chr0_q`, `chr1_q` and `prg_q` are zero, and `reset_seen` is low.
- R2: An accepted write with `din_msb`=1, at any `addr_sel`, empties the shift register and sets `ctrl_q[3:2]` to 2'b11 while `ctrl_q[4]` and `ctrl_q[1:0]` keep their values. `reset_seen` is high for exactly the one cycle after that clock edge.
- R3: Accepted writes with `din_msb`=0 shift `din_lsb` in, least significant bit first. The first write's bit becomes bit 0 of the value and the fifth write's bit becomes bit 4.
- R4: On the fifth accepted data write the value is committed to the register picked by that write's `addr_sel`: 2'b00 `ctrl_q`, 2'b01 `chr0_q`, 2'b10 `chr1_q`, 2'b11 `prg_q`. The new value is visible after that clock edge, and the other three registers keep their values.
- R5: `addr_sel` has no effect on the first four data writes of a value.
- R6: After a commit the shift register is empty again, so the next five data writes form a fresh value with no reset write in between.
- R7: A write in the cycle right after a write cycle is ignored entirely (no shift, no reset, no commit, no pulse), whatever its data or select. Such a write still counts as a write cycle, so a third write in a row is ignored as well.
- R8: In cycles without an accepted write no register changes and `reset_seen` stays low.
- R9: A reset write during a partly shifted value discards the bits already shifted in. The next five data writes form the value on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe for the loader range |
| addr_sel | input | 2 | Register select (address bits 14:13) |
| din_msb | input | 1 | Data bit 7: reset request |
| din_lsb | input | 1 | Data bit 0: serial data |
| ctrl_q | output | 5 | Control register |
| chr0_q | output | 5 | First pattern bank register |
| chr1_q | output | 5 | Second pattern bank register |
| prg_q | output | 5 | Program bank register |
| reset_seen | output | 1 | One-cycle pulse after an accepted reset write |

## Verification
Every result of an accepted write is registered. It is due exactly one clock edge after the cycle that carries the write: the committed register, the forced control bits and the `reset_seen` pulse all appear together after that edge. The bench drives one input set per cycle at the falling edge and queues what all outputs should show after the next rising edge. The monitor checks that entry one nanosecond after the rising edge. Idle and filtered cycles also queue an entry, so the bench sees any change that shows up a cycle early or late.

// File: rtl/serial_loader_pkg.sv
package serial_loader_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_CHR0 = 2'b01,
      SEL_CHR1 = 2'b10,
      SEL_PRG  = 2'b11
   } target_e;

   localparam int unsigned DEF_VAL_W = 5;
   localparam int unsigned DEF_SEL_W = 2;
endpackage

// File: rtl/write_gate.sv
// Drops any write that lands in the cycle right after another write cycle.
module write_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   output logic take
);
   logic wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b0;
      else        wr_prev <= wr_en;
   end

   assign take = wr_en & ~wr_prev;
endmodule

// File: rtl/marker_shifter.sv
// Shift register with a marker bit: empty = 1 followed by zeros, full once
// the marker reaches bit 0.
module marker_shifter #(
   parameter int unsigned VAL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_data,
   input  logic             take_clear,
   input  logic             bit_in,
   output logic             commit,
   output logic [VAL_W-1:0] value
);
   localparam logic [VAL_W-1:0] EMPTY = {1'b1, {(VAL_W-1){1'b0}}};

   logic [VAL_W-1:0] sr_q;

   assign commit = take_data & sr_q[0];
   assign value  = {bit_in, sr_q[VAL_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sr_q <= EMPTY;
      else if (take_clear) sr_q <= EMPTY;
      else if (commit)     sr_q <= EMPTY;
      else if (take_data)  sr_q <= {bit_in, sr_q[VAL_W-1:1]};
   end
endmodule

// File: rtl/target_regs.sv
// Bank of holding registers; entry 0 is the control register, which also
// takes the forced-mode OR on a reset write.
module target_regs #(
   parameter int unsigned      VAL_W      = 5,
   parameter int unsigned      SEL_W      = 2,
   parameter logic [VAL_W-1:0] CTRL_FORCE = 5'b01100,
   localparam int unsigned     NREG       = 1 << SEL_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       commit,
   input  logic [SEL_W-1:0]           sel,
   input  logic [VAL_W-1:0]           value,
   input  logic                       force_mode,
   output logic [NREG-1:0][VAL_W-1:0] regs_q
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic hit;
      assign hit = commit && (sel == SEL_W'(i));
      if (i == 0) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          regs_q[i] <= CTRL_FORCE;
            else if (force_mode) regs_q[i] <= regs_q[i] | CTRL_FORCE;
            else if (hit)        regs_q[i] <= value;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   regs_q[i] <= '0;
            else if (hit) regs_q[i] <= value;
         end
      end
   end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
   parameter int unsigned      VAL_W      = serial_loader_pkg::DEF_VAL_W,
   parameter int unsigned      SEL_W      = serial_loader_pkg::DEF_SEL_W,
   parameter logic [VAL_W-1:0] CTRL_FORCE = 5'b01100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] addr_sel,
   input  logic             din_msb,
   input  logic             din_lsb,
   output logic [VAL_W-1:0] ctrl_q,
   output logic [VAL_W-1:0] chr0_q,
   output logic [VAL_W-1:0] chr1_q,
   output logic [VAL_W-1:0] prg_q,
   output logic             reset_seen
);
   import serial_loader_pkg::*;

   localparam int unsigned NREG = 1 << SEL_W;

   if (SEL_W != 2) begin : g_bad_sel
      $error("serial_reg_loader: four target ports need SEL_W == 2");
   end
   if (VAL_W < 2) begin : g_bad_w
      $error("serial_reg_loader: VAL_W must be at least 2");
   end

   logic                       take;
   logic                       take_clear;
   logic                       take_data;
   logic                       commit;
   logic [VAL_W-1:0]           value;
   logic [NREG-1:0][VAL_W-1:0] regs_q;
   logic                       pulse_q;

   write_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .take  (take)
   );

   assign take_clear = take &  din_msb;
   assign take_data  = take & ~din_msb;

   marker_shifter #(.VAL_W(VAL_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_data  (take_data),
      .take_clear (take_clear),
      .bit_in     (din_lsb),
      .commit     (commit),
      .value      (value)
   );

   target_regs #(
      .VAL_W      (VAL_W),
      .SEL_W      (SEL_W),
      .CTRL_FORCE (CTRL_FORCE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .sel        (addr_sel),
      .value      (value),
      .force_mode (take_clear),
      .regs_q     (regs_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= take_clear;
   end

   assign ctrl_q     = regs_q[SEL_CTRL];
   assign chr0_q     = regs_q[SEL_CHR0];
   assign chr1_q     = regs_q[SEL_CHR1];
   assign prg_q      = regs_q[SEL_PRG];
   assign reset_seen = pulse_q;
endmodule

// File: rtl/serial_reg_loader_chk.sv
module serial_reg_loader_chk #(
   parameter int unsigned      VAL_W      = 5,
   parameter int unsigned      SEL_W      = 2,
   parameter logic [VAL_W-1:0] CTRL_FORCE = 5'b01100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [SEL_W-1:0] addr_sel,
   input logic             din_msb,
   input logic             din_lsb,
   input logic [VAL_W-1:0] ctrl_q,
   input logic [VAL_W-1:0] chr0_q,
   input logic [VAL_W-1:0] chr1_q,
   input logic [VAL_W-1:0] prg_q,
   input logic             reset_seen
);
   logic seen_wr;
   logic acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_wr <= 1'b0;
      else        seen_wr <= wr_en;
   end
   assign acc = wr_en && !seen_wr;

   // R2: reset write forces the mode bits and raises the pulse
   a_r2_reset_forces_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && din_msb) |=> (reset_seen && ((ctrl_q & CTRL_FORCE) == CTRL_FORCE)));

   // R2: the other control bits survive a reset write
   a_r2_other_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && din_msb) |=> ((ctrl_q & ~CTRL_FORCE) == ($past(ctrl_q) & ~CTRL_FORCE)));

   // R2: the pulse lasts one cycle
   a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen |=> !reset_seen);

   // R4: at most one register changes per edge
   a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl_q != $past(ctrl_q), chr0_q != $past(chr0_q),
                chr1_q != $past(chr1_q), prg_q != $past(prg_q)}));

   // R7: a write right after a write changes nothing
   a_r7_second_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && seen_wr) |=> (!reset_seen && $stable(ctrl_q) && $stable(chr0_q)
                              && $stable(chr1_q) && $stable(prg_q)));

   // R8: idle cycles change nothing
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!reset_seen && $stable(ctrl_q) && $stable(chr0_q)
                  && $stable(chr1_q) && $stable(prg_q)));

   logic unused_ok;
   assign unused_ok = ^{addr_sel, din_lsb};
endmodule

bind serial_reg_loader serial_reg_loader_chk #(
   .VAL_W      (VAL_W),
   .SEL_W      (SEL_W),
   .CTRL_FORCE (CTRL_FORCE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr_sel   (addr_sel),
   .din_msb    (din_msb),
   .din_lsb    (din_lsb),
   .ctrl_q     (ctrl_q),
   .chr0_q     (chr0_q),
   .chr1_q     (chr1_q),
   .prg_q      (prg_q),
   .reset_seen (reset_seen)
);

// File: tb/serial_reg_loader_tb.sv
`timescale 1ns/1ps
module serial_reg_loader_tb;
   typedef struct {
      string      tag;
      logic [4:0] c, k0, k1, p;
      logic       pl;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr_sel = 2'b00;
   logic       din_msb = 1'b0;
   logic       din_lsb = 1'b0;
   logic [4:0] ctrl_q, chr0_q, chr1_q, prg_q;
   logic       reset_seen;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t q[$];

   // reference state, kept as a bit count plus collected value
   logic [4:0] m_c = 5'b01100, m_k0 = '0, m_k1 = '0, m_p = '0;
   logic [4:0] m_acc = '0;
   int         m_cnt = 0;
   logic       m_prev = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   serial_reg_loader u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_sel(addr_sel),
      .din_msb(din_msb), .din_lsb(din_lsb), .ctrl_q(ctrl_q), .chr0_q(chr0_q),
      .chr1_q(chr1_q), .prg_q(prg_q), .reset_seen(reset_seen)
   );

   task automatic cmp(string tag, logic [4:0] c, logic [4:0] k0, logic [4:0] k1,
                      logic [4:0] p, logic pl);
      checks++;
      if (ctrl_q !== c || chr0_q !== k0 || chr1_q !== k1 || prg_q !== p || reset_seen !== pl) begin
         errors++;
         $display("FAIL %s got ctrl=%b chr0=%b chr1=%b prg=%b pulse=%b exp ctrl=%b chr0=%b chr1=%b prg=%b pulse=%b",
                  tag, ctrl_q, chr0_q, chr1_q, prg_q, reset_seen, c, k0, k1, p, pl);
      end
   endtask

   // driver: one input set per cycle, expected outputs queued
   task automatic cyc(string tag, logic w, logic [1:0] s, logic msb, logic lsb);
      exp_t e;
      logic pl = 1'b0;
      @(negedge clk);
      wr_en = w; addr_sel = s; din_msb = msb; din_lsb = lsb;
      if (w && !m_prev) begin
         if (msb) begin
            m_cnt = 0; m_acc = '0; m_c = m_c | 5'b01100; pl = 1'b1;
         end else if (m_cnt == 4) begin
            m_acc[4] = lsb;
            case (s)
               2'b00: m_c  = m_acc;
               2'b01: m_k0 = m_acc;
               2'b10: m_k1 = m_acc;
               default: m_p = m_acc;
            endcase
            m_cnt = 0; m_acc = '0;
         end else begin
            m_acc[m_cnt] = lsb; m_cnt++;
         end
      end
      m_prev = w;
      e.tag = tag; e.c = m_c; e.k0 = m_k0; e.k1 = m_k1; e.p = m_p; e.pl = pl;
      q.push_back(e);
   endtask

   task automatic idle(string tag);
      cyc(tag, 1'b0, 2'b00, 1'b0, 1'b0);
   endtask

   // five data writes, idle between; junk selects on the first four
   task automatic load(string tag, logic [1:0] s, logic [4:0] v);
      for (int i = 0; i < 5; i++) begin
         cyc(tag, 1'b1, (i == 4) ? s : 2'(i * 3 + 1), 1'b0, v[i]);
         idle(tag);
      end
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         cmp(e.tag, e.c, e.k0, e.k1, e.p, e.pl);
      end
   end

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      cmp("R1 reset state", 5'b01100, 5'd0, 5'd0, 5'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R8 idle after reset");
      idle("R8 idle after reset");

      load("R3 R5 lsb-first into prg", 2'b11, 5'b10110);
      load("R4 chr0 target", 2'b01, 5'b01011);
      load("R4 R6 chr1 target, no reset between", 2'b10, 5'b11101);
      load("R4 ctrl target", 2'b00, 5'b10011);
      cyc("R2 reset write forces ctrl[3:2]", 1'b1, 2'b10, 1'b1, 1'b0);
      idle("R2 pulse lasts one cycle");
      idle("R8 idle");

      // R9: partial value abandoned
      cyc("R9 partial bit 1", 1'b1, 2'b00, 1'b0, 1'b1); idle("R9");
      cyc("R9 partial bit 2", 1'b1, 2'b00, 1'b0, 1'b1); idle("R9");
      cyc("R9 reset mid value", 1'b1, 2'b01, 1'b1, 1'b1); idle("R9");
      load("R9 fresh value after reset", 2'b10, 5'b00110);

      // R7: back-to-back writes
      cyc("R7 first write accepted", 1'b1, 2'b00, 1'b0, 1'b1);
      cyc("R7 reset right after write ignored", 1'b1, 2'b00, 1'b1, 1'b0);
      cyc("R7 third in a row ignored", 1'b1, 2'b11, 1'b0, 1'b0);
      idle("R7");
      cyc("R7 bit 2", 1'b1, 2'b00, 1'b0, 1'b0); idle("R7");
      cyc("R7 bit 3", 1'b1, 2'b00, 1'b0, 1'b1); idle("R7");
      cyc("R7 bit 4", 1'b1, 2'b00, 1'b0, 1'b0); idle("R7");
      cyc("R7 fifth write commits to prg", 1'b1, 2'b11, 1'b0, 1'b1);
      cyc("R7 write after commit ignored", 1'b1, 2'b01, 1'b0, 1'b1);
      idle("R8 idle");
      load("R6 next value to chr0", 2'b01, 5'b11111);
      cyc("R2 reset with ctrl bits set", 1'b1, 2'b11, 1'b1, 1'b1);
      idle("R8 final idle");
      idle("R8 final idle");

      @(posedge clk); #2;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule